// File: doc/BRIEF.md
# Shader address and loop control

This block keeps the address state of a small vertex-shader core. It holds two general address registers (the a0 pair, here `a0x` and `a0y`) and a loop counter `al`. It also runs the control for one counted loop at a time. The decoder gives it the opcode, the program counter of the instruction, the two leading float components of the source operand, the source register number with its relative-index selector, a packed integer loop uniform, and the loop-end address. From these the block returns the effective register-file index of the source operand in the same cycle. It also tells the fetch unit, one cycle after the last instruction of a pass issues, whether to jump back to the loop body or to continue past it.

Loop control is a two-state machine. In `LS_IDLE` no loop is open. The transition *enter* (a loop instruction) loads the counter and moves to `LS_LOOP`. In `LS_LOOP`, the transition *repeat* (the end instruction issues and the stepped counter is still within bound) stays in `LS_LOOP` and pulses the branch strobe. The transition *exit* (the end instruction issues and the stepped counter is past the bound) pulses fall-through and returns to `LS_IDLE`. The transition *restart* (a loop instruction while in `LS_LOOP`) reloads all loop state and stays in `LS_LOOP`. Nested loops are not tracked.

The counter runs over an inclusive range: it starts at the uniform's start field and stops once it exceeds start plus count. It keeps its last value after the loop closes, and it can serve as a third relative index.

Top module: `shd_addr_loop`

## Requirements
- R1: While `rst_n` is low, `a0x`, `a0y` and `al` read 0, and `branch_back` and `fall_through` are low.
- R2: An instruction with `instr_valid` high and `opcode` 0x12 loads `a0x` from `src_x` and `a0y` from `src_y`, each converted to an integer, visible after the next rising edge. Any other opcode, or `instr_valid` low, leaves both registers unchanged.
- R3: The conversion takes an IEEE-754 single value and truncates toward zero: 3.7 gives 3, -3.7 gives -3, 0.5 gives 0, 127.5 gives 127.
- R4: The conversion saturates to the signed 8-bit range: 200.0 and +infinity give 127, while -300.0, -128.0 and -infinity give -128.
- R5: `eff_idx` is a combinational function of the current register values. It equals `src_num` plus the sign-extended register picked by `rel_sel`, modulo 128. The codes are 0 for no offset, 1 for `a0x`, 2 for `a0y` and 3 for `al`.
- R6: An instruction with `instr_valid` high and `opcode` 0x29 opens a loop. `loop_uniform` bits [7:0] give the count x, bits [15:8] the start y, and bits [23:16] the step z. After the next edge, `al` equals y. The loop start address is `instr_pc`+1 and the end address is `loop_end`.
- R7: In a loop, a valid non-loop instruction whose `instr_pc` equals the end address adds z to the counter. If the new value is at most x+y, `branch_back` pulses for one cycle after the edge, with `branch_target` equal to the loop start. Otherwise `fall_through` pulses for one cycle and the loop closes. The body therefore runs floor(x/z)+1 times.
- R8: After the loop exits, `al` keeps the low 8 bits (read as signed) of the final counter value, which is y plus the number of passes times z. It stays usable as a relative index until the next loop instruction.
- R9: With no loop open, an instruction at the old end address raises neither strobe and leaves `al` unchanged.
- R10: Instructions in the body other than the end instruction, and any cycle with `instr_valid` low even at the end address, raise neither strobe and leave the counter unchanged.
- R11: A loop instruction issued while a loop is open restarts the loop with the new uniform and addresses. The old end address no longer ends a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction issues this cycle |
| opcode | input | 6 | Instruction opcode |
| instr_pc | input | ADDR_W (12) | Address of the issuing instruction |
| src_x | input | 32 | Source component 0, IEEE-754 single |
| src_y | input | 32 | Source component 1, IEEE-754 single |
| src_num | input | IDX_W (7) | Source register number before offset |
| rel_sel | input | 2 | Relative-index selector |
| loop_uniform | input | 3*UNI_W (24) | Packed count, start and step |
| loop_end | input | ADDR_W (12) | Address of the last body instruction |
| eff_idx | output | IDX_W (7) | Effective source register index |
| a0x | output | AR_W (8) | Address register x, signed |
| a0y | output | AR_W (8) | Address register y, signed |
| al | output | AR_W (8) | Loop counter, signed view |
| branch_back | output | 1 | One-cycle strobe: jump to loop start |
| branch_target | output | ADDR_W (12) | Loop start address |
| fall_through | output | 1 | One-cycle strobe: loop finished |

## Verification
The bench targets the inclusive bound. Take a loop with count 4, start 2 and step 2: it must run three passes and leave the counter at 8. A design that compares with "less than" would exit one pass early, and one that does not keep the final value would show 6 or 0. The bench drives conversion cases where rounding instead of truncation, or wrapping instead of saturation, gives a visibly different register value (3.7, 200.0, -300.0, infinities). It checks index sums that cross the modulo-128 boundary in both directions, so that a missing sign extension or a missing wrap shows up as a wrong index. It also checks that a loop restart discards the old end address, and that the end address does nothing when no loop is open or when `instr_valid` is low; a design that got these wrong would emit stray branch strobes.

// File: rtl/shd_addr_pkg.sv
package shd_addr_pkg;
    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] OP_ARLOAD = 6'h12;
    localparam logic [OPC_W-1:0] OP_LOOP   = 6'h29;

    typedef enum logic [1:0] {
        REL_NONE = 2'd0,
        REL_A0X  = 2'd1,
        REL_A0Y  = 2'd2,
        REL_CNT  = 2'd3
    } rel_sel_e;

    typedef enum logic [0:0] {
        LS_IDLE = 1'b0,
        LS_LOOP = 1'b1
    } loop_state_e;
endpackage

// File: rtl/shd_f2i.sv
// Float (IEEE-754 single) to signed integer, truncating toward zero,
// saturating at the limits of an OUT_W-bit two's complement value.
module shd_f2i #(
    parameter int OUT_W = 8
) (
    input  logic [31:0]             f_i,
    output logic signed [OUT_W-1:0] i_o
);
    localparam int BIAS    = 127;
    localparam int SAT_EXP = BIAS + OUT_W - 1;   // magnitude >= 2^(OUT_W-1)
    localparam int FRAC_LSB_EXP = BIAS + 23;

    logic             sgn;
    logic [7:0]       ex;
    logic [23:0]      sig;
    logic [OUT_W-1:0] mag;

    always_comb begin
        sgn = f_i[31];
        ex  = f_i[30:23];
        sig = {1'b1, f_i[22:0]};
        mag = '0;
        if (int'(ex) >= SAT_EXP) begin
            i_o = sgn ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
        end else if (int'(ex) < BIAS) begin
            i_o = '0;
        end else begin
            mag = OUT_W'(sig >> (FRAC_LSB_EXP - int'(ex)));
            i_o = sgn ? -mag : mag;
        end
    end
endmodule

// File: rtl/shd_idx_calc.sv
// Effective register index: base number plus a selected signed offset,
// wrapping modulo the register-file size.
module shd_idx_calc import shd_addr_pkg::*; #(
    parameter int IDX_W = 7,
    parameter int AR_W  = 8
) (
    input  logic [IDX_W-1:0]       base_i,
    input  logic [1:0]             sel_i,
    input  logic signed [AR_W-1:0] a0x_i,
    input  logic signed [AR_W-1:0] a0y_i,
    input  logic signed [AR_W-1:0] cnt_i,
    output logic [IDX_W-1:0]       idx_o
);
    localparam int EXT_W = AR_W + IDX_W;

    logic [AR_W-1:0]  pick;
    logic [EXT_W-1:0] ext;

    always_comb begin
        unique case (rel_sel_e'(sel_i))
            REL_NONE: pick = '0;
            REL_A0X:  pick = a0x_i;
            REL_A0Y:  pick = a0y_i;
            REL_CNT:  pick = cnt_i;
            default:  pick = '0;
        endcase
        ext   = {{IDX_W{pick[AR_W-1]}}, pick};
        idx_o = base_i + ext[IDX_W-1:0];
    end
endmodule

// File: rtl/shd_loop_ctl.sv
// Single-level counted loop controller with an inclusive upper bound.
module shd_loop_ctl import shd_addr_pkg::*; #(
    parameter int ADDR_W = 12,
    parameter int UNI_W  = 8,
    parameter int AR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid_i,
    input  logic              is_loop_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic [UNI_W-1:0]  cnt_x_i,
    input  logic [UNI_W-1:0]  start_y_i,
    input  logic [UNI_W-1:0]  step_z_i,
    output logic [AR_W-1:0]   al_o,
    output logic              branch_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              exit_o
);
    localparam int BND_W = UNI_W + 1;
    localparam int CNT_W = UNI_W + 2;

    loop_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BND_W-1:0]  bound_q, bound_d;
    logic [UNI_W-1:0]  step_q, step_d;
    logic [ADDR_W-1:0] top_q, top_d;
    logic [ADDR_W-1:0] end_q, end_d;
    logic              branch_d, exit_d;
    logic              enter, pass_end;

    assign enter    = instr_valid_i && is_loop_i;
    assign pass_end = instr_valid_i && !is_loop_i && (pc_i == end_q);

    // next-state and strobe decode
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        bound_d  = bound_q;
        step_d   = step_q;
        top_d    = top_q;
        end_d    = end_q;
        branch_d = 1'b0;
        exit_d   = 1'b0;
        if (enter) begin
            // enter from LS_IDLE, restart from LS_LOOP
            cnt_d   = CNT_W'(start_y_i);
            bound_d = BND_W'(cnt_x_i) + BND_W'(start_y_i);
            step_d  = step_z_i;
            top_d   = pc_i + ADDR_W'(1);
            end_d   = end_addr_i;
            state_d = LS_LOOP;
        end else begin
            unique case (state_q)
                LS_IDLE: ;
                LS_LOOP: begin
                    if (pass_end) begin
                        cnt_d = cnt_q + CNT_W'(step_q);
                        if (cnt_d <= CNT_W'(bound_q)) begin
                            branch_d = 1'b1;         // repeat
                        end else begin
                            exit_d  = 1'b1;          // exit
                            state_d = LS_IDLE;
                        end
                    end
                end
                default: state_d = LS_IDLE;
            endcase
        end
    end

    // state register and loop data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            cnt_q   <= '0;
            bound_q <= '0;
            step_q  <= '0;
            top_q   <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bound_q <= bound_d;
            step_q  <= step_d;
            top_q   <= top_d;
            end_q   <= end_d;
        end
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            branch_o <= 1'b0;
            exit_o   <= 1'b0;
        end else begin
            branch_o <= branch_d;
            exit_o   <= exit_d;
        end
    end

    assign al_o     = cnt_q[AR_W-1:0];
    assign target_o = top_q;
endmodule

// File: rtl/shd_addr_loop.sv
module shd_addr_loop import shd_addr_pkg::*; #(
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 12,
    parameter int AR_W   = 8,
    parameter int UNI_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   instr_valid,
    input  logic [OPC_W-1:0]       opcode,
    input  logic [ADDR_W-1:0]      instr_pc,
    input  logic [31:0]            src_x,
    input  logic [31:0]            src_y,
    input  logic [IDX_W-1:0]       src_num,
    input  logic [1:0]             rel_sel,
    input  logic [3*UNI_W-1:0]     loop_uniform,
    input  logic [ADDR_W-1:0]      loop_end,
    output logic [IDX_W-1:0]       eff_idx,
    output logic signed [AR_W-1:0] a0x,
    output logic signed [AR_W-1:0] a0y,
    output logic signed [AR_W-1:0] al,
    output logic                   branch_back,
    output logic [ADDR_W-1:0]      branch_target,
    output logic                   fall_through
);
    localparam int NCOMP = 2;

    logic [31:0]            comp_f [NCOMP];
    logic signed [AR_W-1:0] comp_i [NCOMP];
    logic                   ld_ar;
    logic [AR_W-1:0]        al_raw;

    assign comp_f[0] = src_x;
    assign comp_f[1] = src_y;

    for (genvar g = 0; g < NCOMP; g++) begin : g_cvt
        shd_f2i #(.OUT_W(AR_W)) u_f2i (
            .f_i (comp_f[g]),
            .i_o (comp_i[g])
        );
    end

    assign ld_ar = instr_valid && (opcode == OP_ARLOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a0x <= '0;
            a0y <= '0;
        end else if (ld_ar) begin
            a0x <= comp_i[0];
            a0y <= comp_i[1];
        end
    end

    shd_loop_ctl #(.ADDR_W(ADDR_W), .UNI_W(UNI_W), .AR_W(AR_W)) u_loop (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid_i (instr_valid),
        .is_loop_i     (opcode == OP_LOOP),
        .pc_i          (instr_pc),
        .end_addr_i    (loop_end),
        .cnt_x_i       (loop_uniform[UNI_W-1:0]),
        .start_y_i     (loop_uniform[2*UNI_W-1:UNI_W]),
        .step_z_i      (loop_uniform[3*UNI_W-1:2*UNI_W]),
        .al_o          (al_raw),
        .branch_o      (branch_back),
        .target_o      (branch_target),
        .exit_o        (fall_through)
    );

    assign al = al_raw;

    shd_idx_calc #(.IDX_W(IDX_W), .AR_W(AR_W)) u_idx (
        .base_i (src_num),
        .sel_i  (rel_sel),
        .a0x_i  (a0x),
        .a0y_i  (a0y),
        .cnt_i  (al),
        .idx_o  (eff_idx)
    );
endmodule

// File: rtl/shd_addr_loop_chk.sv
module shd_addr_loop_chk import shd_addr_pkg::*; #(
    parameter int IDX_W  = 7,
    parameter int AR_W   = 8,
    parameter int UNI_W  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   instr_valid,
    input logic [OPC_W-1:0]       opcode,
    input logic [IDX_W-1:0]       src_num,
    input logic [1:0]             rel_sel,
    input logic [3*UNI_W-1:0]     loop_uniform,
    input logic [IDX_W-1:0]       eff_idx,
    input logic signed [AR_W-1:0] a0x,
    input logic signed [AR_W-1:0] a0y,
    input logic signed [AR_W-1:0] al,
    input logic                   branch_back,
    input logic                   fall_through
);
    // R2: address registers move only on a valid load instruction
    p_hold_ar_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && opcode == OP_ARLOAD) |=> ($stable(a0x) && $stable(a0y)));

    // R5: selector 0 passes the source number through
    p_no_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_sel == 2'd0) |-> (eff_idx == src_num));

    // R6: loop entry loads the start field
    p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode == OP_LOOP) |=>
        ($unsigned(al) == AR_W'($past(loop_uniform[2*UNI_W-1:UNI_W]))));

    // R7: the two pass-end strobes never coincide
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(branch_back && fall_through));

    // R8: counter holds after exit unless a new loop starts
    p_keep_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_through && !(instr_valid && opcode == OP_LOOP)) |=> $stable(al));
endmodule

bind shd_addr_loop shd_addr_loop_chk #(.IDX_W(IDX_W), .AR_W(AR_W), .UNI_W(UNI_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .opcode       (opcode),
    .src_num      (src_num),
    .rel_sel      (rel_sel),
    .loop_uniform (loop_uniform),
    .eff_idx      (eff_idx),
    .a0x          (a0x),
    .a0y          (a0y),
    .al           (al),
    .branch_back  (branch_back),
    .fall_through (fall_through)
);

// File: tb/sim_shd_addr_loop.sv
module sim_shd_addr_loop;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // {src_x, src_y, src_num, exp a0x, exp a0y, exp idx via a0x, exp idx via a0y}
    localparam logic [103:0] VEC [NVEC] = '{
        {32'h406CCCCD, 32'hC06CCCCD, 8'd8,   8'd3,   8'hFD, 8'd11,  8'd5},
        {32'h3F000000, 32'h43480000, 8'd100, 8'd0,   8'd127, 8'd100, 8'd99},
        {32'hC3960000, 32'hC3000000, 8'd5,   8'h80,  8'h80, 8'd5,   8'd5},
        {32'h42FF0000, 32'hC0000000, 8'd1,   8'd127, 8'hFE, 8'd0,   8'd127},
        {32'h40A00000, 32'h00000000, 8'd127, 8'd5,   8'd0,  8'd4,   8'd127},
        {32'h7F800000, 32'hFF800000, 8'd0,   8'd127, 8'h80, 8'd127, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [11:0] instr_pc = '0;
    logic [31:0] src_x = '0;
    logic [31:0] src_y = '0;
    logic [6:0]  src_num = '0;
    logic [1:0]  rel_sel = '0;
    logic [23:0] loop_uniform = '0;
    logic [11:0] loop_end = '0;
    logic [6:0]  eff_idx;
    logic [7:0]  a0x, a0y, al;
    logic        branch_back, fall_through;
    logic [11:0] branch_target;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shd_addr_loop u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
        .instr_pc(instr_pc), .src_x(src_x), .src_y(src_y), .src_num(src_num),
        .rel_sel(rel_sel), .loop_uniform(loop_uniform), .loop_end(loop_end),
        .eff_idx(eff_idx), .a0x(a0x), .a0y(a0y), .al(al),
        .branch_back(branch_back), .branch_target(branch_target),
        .fall_through(fall_through)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one instruction at the falling edge, return just after the rising edge
    task automatic issue(input logic v, input logic [5:0] op, input logic [11:0] pc,
                         input logic [31:0] fx, input logic [31:0] fy,
                         input logic [23:0] uni, input logic [11:0] lend);
        @(negedge clk);
        instr_valid = v; opcode = op; instr_pc = pc; src_x = fx; src_y = fy;
        loop_uniform = uni; loop_end = lend;
        @(posedge clk);
        #1;
    endtask

    // combinational index probe with no instruction issuing
    task automatic peek(input logic [6:0] num, input logic [1:0] sel);
        @(negedge clk);
        instr_valid = 1'b0; opcode = 6'h00; src_num = num; rel_sel = sel;
        #1;
    endtask

    function automatic logic [23:0] uni(input int x, input int y, input int z);
        return {8'(z), 8'(y), 8'(x)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 a0x reset", 32'(a0x), 0);
        chk("R1 a0y reset", 32'(a0y), 0);
        chk("R1 al reset", 32'(al), 0);
        chk("R1 strobes reset", {30'd0, branch_back, fall_through}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // table: load, convert, index
        for (int i = 0; i < NVEC; i++) begin
            issue(1'b1, 6'h12, 12'd0, VEC[i][103:72], VEC[i][71:40], 24'd0, 12'd0);
            chk("R2 R3 R4 a0x load", 32'(a0x), 32'(VEC[i][31:24]));
            chk("R2 R3 R4 a0y load", 32'(a0y), 32'(VEC[i][23:16]));
            peek(VEC[i][38:32], 2'd1);
            chk("R5 index via a0x", 32'(eff_idx), 32'(VEC[i][15:8]));
            peek(VEC[i][38:32], 2'd2);
            chk("R5 index via a0y", 32'(eff_idx), 32'(VEC[i][7:0]));
            peek(VEC[i][38:32], 2'd0);
            chk("R5 index no offset", 32'(eff_idx), 32'(VEC[i][38:32]));
        end

        // R2: no load when not valid or wrong opcode (last row: 127, -128)
        issue(1'b0, 6'h12, 12'd0, 32'h40A00000, 32'h40A00000, 24'd0, 12'd0);
        chk("R2 invalid no load", 32'({a0x, a0y}), 32'h7F80);
        issue(1'b1, 6'h13, 12'd0, 32'h40A00000, 32'h40A00000, 24'd0, 12'd0);
        chk("R2 other opcode no load", 32'({a0x, a0y}), 32'h7F80);

        // R6/R7: count 4, start 2, step 2 -> passes at 2,4,6, final 8
        issue(1'b1, 6'h29, 12'd10, 0, 0, uni(4, 2, 2), 12'd12);
        chk("R6 entry al", 32'(al), 2);
        for (int p = 0; p < 2; p++) begin
            issue(1'b1, 6'h00, 12'd11, 0, 0, 24'd0, 12'd0);
            chk("R10 body no strobe", {30'd0, branch_back, fall_through}, 0);
            issue(1'b1, 6'h00, 12'd12, 0, 0, 24'd0, 12'd0);
            chk("R7 branch strobe", 32'(branch_back), 1);
            chk("R7 target", 32'(branch_target), 11);
            chk("R7 stepped al", 32'(al), 32'(4 + 2 * p));
        end
        issue(1'b1, 6'h00, 12'd11, 0, 0, 24'd0, 12'd0);
        issue(1'b1, 6'h00, 12'd12, 0, 0, 24'd0, 12'd0);
        chk("R7 exit no branch", 32'(branch_back), 0);
        chk("R7 exit fall", 32'(fall_through), 1);
        chk("R8 final al", 32'(al), 8);
        issue(1'b0, 6'h00, 12'd0, 0, 0, 24'd0, 12'd0);
        chk("R7 one-cycle fall", 32'(fall_through), 0);
        chk("R8 al kept", 32'(al), 8);
        peek(7'd8, 2'd3);
        chk("R8 R5 al as index", 32'(eff_idx), 16);
        issue(1'b1, 6'h00, 12'd12, 0, 0, 24'd0, 12'd0);
        chk("R9 idle end no strobe", {30'd0, branch_back, fall_through}, 0);
        chk("R9 idle al kept", 32'(al), 8);

        // R10: valid low at end address
        issue(1'b1, 6'h29, 12'd40, 0, 0, uni(2, 0, 1), 12'd41);
        issue(1'b0, 6'h00, 12'd41, 0, 0, 24'd0, 12'd0);
        chk("R10 invalid end no strobe", {30'd0, branch_back, fall_through}, 0);
        chk("R10 invalid end al", 32'(al), 0);
        issue(1'b1, 6'h00, 12'd41, 0, 0, 24'd0, 12'd0);
        chk("R7 single-step branch", 32'(branch_back), 1);
        chk("R7 single-step target", 32'(branch_target), 41);

        // R11: restart with count 0, start 250, step 10
        issue(1'b1, 6'h29, 12'd50, 0, 0, uni(0, 250, 10), 12'd52);
        chk("R11 restart al", 32'(al), 250);
        peek(7'd2, 2'd3);
        chk("R5 negative al wraps", 32'(eff_idx), 124);
        issue(1'b1, 6'h00, 12'd41, 0, 0, 24'd0, 12'd0);
        chk("R11 old end ignored", {30'd0, branch_back, fall_through}, 0);
        issue(1'b1, 6'h00, 12'd52, 0, 0, 24'd0, 12'd0);
        chk("R7 zero count single pass", 32'(fall_through), 1);
        chk("R8 final al wraps", 32'(al), 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule